// File: doc/BRIEF.md
# SPI Master Controller with Word FIFOs

This block is a register-mapped SPI master. Software sets a word size and a serial clock divider and then writes words into a data register. The words queue in an eight-entry transmit FIFO. A serial engine takes one word at a time, shifts it out most significant bit first, and captures the same number of bits from the slave into an eight-entry receive FIFO. Software then drains the received words through the same data register. Every word sent yields exactly one word received.

Status and interrupt registers report FIFO occupancy. A single level interrupt goes high when a threshold source is enabled in the mask. A loopback mode moves words straight from the transmit queue into the receive queue without touching the pins. The engine never takes a new word while the receive FIFO has no room. It resumes by itself once software drains a word.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, status (0x0C) reads 0x03, raw interrupts (0x18) read 0x08, the mask (0x14) reads 0, irqOut is low, csNOut is high and sclkOut is low.
- R2: With f = bits [3:0] of control 0 (0x00), every word pushed to the transmit FIFO and every word pushed to the receive FIFO is ANDed with (2^(f+1))-1.
- R3: Both FIFOs hold 8 words. A data write (0x08) to a full transmit FIFO is dropped. A data read from an empty receive FIFO returns 0 and leaves the status unchanged.
- R4: Status bit 0 is transmit empty, bit 1 is transmit not full, bit 2 is receive not empty, bit 3 is receive full, and bit 4 is busy, which is set whenever the transmit FIFO holds a word.
- R5: Raw interrupt bit 2 is set while the receive FIFO holds 4 or more words. Raw bit 3 is set while the transmit FIFO holds 4 or fewer words. Offset 0x1C reads raw AND mask, and irqOut is high when that value is non-zero.
- R6: Words leave the transmit FIFO only while the enable bit (bit 1 of control 1, 0x04) is set. While it is clear, both FIFOs keep their contents.
- R7: A word is taken from the transmit FIFO only when the receive FIFO is not full. Taking words resumes without software action after a receive word is read.
- R8: With loopback (bit 1 of control 1 and bit 0 of control 1 both set), each queued word is moved into the receive FIFO unchanged apart from the mask, and csNOut stays high.
- R9: On the pins, sclkOut idles low, mosiOut carries the word MSB first and changes after falling edges, and misoIn is sampled at rising edges. Each word sent produces exactly one received word.
- R10: sclkOut toggles every P system clocks, where P is the prescale register (0x10). A value of 0 acts as 2. A write keeps only the low 8 bits.
- R11: csNOut falls when the first word of a burst starts, stays low while queued words follow back to back, and rises one serial period (2P clocks) after the last falling edge.
- R12: Offsets 0xFE0 to 0xFFC read the bytes 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, one per 32-bit word. Offset 0x20 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | AW | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe; a data read pops the receive FIFO at the clock edge |
| busRdData | output | 32 | Read data, combinational from busAddr |
| irqOut | output | 1 | Level interrupt: any unmasked raw source |
| sclkOut | output | 1 | Serial clock, idle low |
| csNOut | output | 1 | Active-low chip select |
| mosiOut | output | 1 | Serial data to the slave |
| misoIn | input | 1 | Serial data from the slave |

## Verification
The in-line assertions watch, on every cycle, that neither FIFO is pushed when full or popped when empty. They also check that a word is only fetched while enabled and while the receive FIFO has room, that chip select drops right after a word is fetched, and that the serial clock stays low while deselected. Only the bench scenarios can show the data itself: the masking per word size, the order through both FIFOs, the exact bits exchanged with a slave model, the measured half-period and tail lengths, the threshold interrupts and the identification window.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  // Strobes from the control unit to the datapath, one cycle each
  typedef struct packed {
    logic txPush;     // bus word into transmit FIFO
    logic rxPop;      // bus read out of receive FIFO
    logic wordLoad;   // pop transmit FIFO into the shifter
    logic bitSample;  // rising serial edge: capture misoIn
    logic wordDone;   // last falling edge: push captured word
    logic loopMove;   // loopback: transmit head straight to receive FIFO
  } spiStrobe_t;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_TAIL  = 2'd2
  } engState_t;

endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
  parameter int DEPTH = 8,
  parameter int W     = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       push,
  input  logic [W-1:0]               pushData,
  input  logic                       pop,
  output logic [W-1:0]               headData,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_C = PW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic          pushOk, popOk;

  assign pushOk   = push && (count != FULL_C);
  assign popOk    = pop && (count != '0);
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST_C) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == LAST_C) ? '0 : rdPtr + 1'b1;
      if (pushOk && !popOk)      count <= count + 1'b1;
      else if (popOk && !pushOk) count <= count - 1'b1;
    end
  end

  // R3: the control unit must never push a full queue or pop an empty one
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (count != FULL_C));
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0));

endmodule

// File: rtl/spi_fifo_dp.sv
module spi_fifo_dp
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  spiStrobe_t                 strb,
  input  logic [DW-1:0]              wrWord,
  input  logic [DW-1:0]              dataMask,
  input  logic [$clog2(DW)-1:0]      bitIdx,
  input  logic                       misoIn,
  output logic                       mosiOut,
  output logic [$clog2(DEPTH+1)-1:0] txCount,
  output logic [$clog2(DEPTH+1)-1:0] rxCount,
  output logic [DW-1:0]              rxHead
);
  logic [DW-1:0] txHead, txShift, rxShift, rxPushData;
  logic          txPop, rxPush;

  assign txPop      = strb.wordLoad | strb.loopMove;
  assign rxPush     = strb.wordDone | strb.loopMove;
  assign rxPushData = (strb.loopMove ? txHead : rxShift) & dataMask;
  assign mosiOut    = txShift[bitIdx];

  spi_fifo_buf #(.DEPTH(DEPTH), .W(DW)) i_txBuf (
    .clk(clk), .rstN(rstN),
    .push(strb.txPush), .pushData(wrWord & dataMask),
    .pop(txPop), .headData(txHead), .count(txCount)
  );

  spi_fifo_buf #(.DEPTH(DEPTH), .W(DW)) i_rxBuf (
    .clk(clk), .rstN(rstN),
    .push(rxPush), .pushData(rxPushData),
    .pop(strb.rxPop), .headData(rxHead), .count(rxCount)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else if (strb.wordLoad) begin
      txShift <= txHead;
      rxShift <= '0;
    end else if (strb.bitSample) begin
      rxShift <= {rxShift[DW-2:0], misoIn};
    end
  end

endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int AW    = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [AW-1:0]              addr,
  input  logic                       wrEn,
  input  logic [31:0]                wrData,
  input  logic                       rdEn,
  output logic [31:0]                rdData,
  input  logic [$clog2(DEPTH+1)-1:0] txCount,
  input  logic [$clog2(DEPTH+1)-1:0] rxCount,
  input  logic [DW-1:0]              rxHead,
  output spiStrobe_t                 strb,
  output logic [DW-1:0]              dataMask,
  output logic [$clog2(DW)-1:0]      bitIdx,
  output logic                       sclkOut,
  output logic                       csNOut,
  output logic                       irqOut
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int SW = $clog2(DW);
  localparam logic [CW-1:0] FULL_C    = CW'(DEPTH);
  localparam logic [CW-1:0] FULL_M1_C = CW'(DEPTH-1);
  localparam logic [CW-1:0] HALF_C    = CW'(DEPTH/2);
  localparam logic [DW-1:0] ONES_C    = '1;
  localparam logic [SW-1:0] TOP_C     = SW'(DW-1);

  localparam logic [AW-1:0] OFS_CTRL0 = AW'('h00);
  localparam logic [AW-1:0] OFS_CTRL1 = AW'('h04);
  localparam logic [AW-1:0] OFS_DATA  = AW'('h08);
  localparam logic [AW-1:0] OFS_STAT  = AW'('h0C);
  localparam logic [AW-1:0] OFS_PRE   = AW'('h10);
  localparam logic [AW-1:0] OFS_IMSK  = AW'('h14);
  localparam logic [AW-1:0] OFS_RAW   = AW'('h18);
  localparam logic [AW-1:0] OFS_MIS   = AW'('h1C);
  localparam logic [AW-1:0] OFS_ID    = AW'('hFE0);

  logic [15:0] ctrl0;
  logic [3:0]  ctrl1;
  logic [7:0]  prescale;
  logic [3:0]  intMask;
  logic [3:0]  rawIrq;
  logic [4:0]  statBits;
  logic        enable, loopSel, txHasWord;

  engState_t   state, nextState;
  logic [7:0]  halfCnt, divLim;
  logic        tick, sclkR, csNR, tailHalf;
  logic        unusedBits;

  assign unusedBits = &{1'b0, wrData[31:16]};

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    case (idx)
      3'd0: idByte = 8'h22;
      3'd1: idByte = 8'h10;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl0    <= '0;
      ctrl1    <= '0;
      prescale <= '0;
      intMask  <= '0;
    end else if (wrEn) begin
      case (addr)
        OFS_CTRL0: ctrl0    <= wrData[15:0];
        OFS_CTRL1: ctrl1    <= wrData[3:0];
        OFS_PRE:   prescale <= wrData[7:0];
        OFS_IMSK:  intMask  <= wrData[3:0];
        default: ;
      endcase
    end
  end

  assign enable    = ctrl1[1];
  assign loopSel   = ctrl1[0];
  assign txHasWord = (txCount != '0);
  assign dataMask  = ONES_C >> (TOP_C - ctrl0[SW-1:0]);

  assign statBits = {txHasWord, rxCount == FULL_C, rxCount != '0,
                     txCount != FULL_C, !txHasWord};
  assign rawIrq   = {txCount <= HALF_C, rxCount >= HALF_C, 2'b00};
  assign irqOut   = |(rawIrq & intMask);

  always_comb begin
    rdData = '0;
    if (addr >= OFS_ID) begin
      rdData = 32'(idByte(addr[4:2]));
    end else begin
      case (addr)
        OFS_CTRL0: rdData = 32'(ctrl0);
        OFS_CTRL1: rdData = 32'(ctrl1);
        OFS_DATA:  rdData = (rxCount != '0) ? 32'(rxHead) : '0;
        OFS_STAT:  rdData = 32'(statBits);
        OFS_PRE:   rdData = 32'(prescale);
        OFS_IMSK:  rdData = 32'(intMask);
        OFS_RAW:   rdData = 32'(rawIrq);
        OFS_MIS:   rdData = 32'(rawIrq & intMask);
        default:   rdData = '0;
      endcase
    end
  end

  // ---------------- serial engine ----------------
  assign divLim = (prescale == '0) ? 8'd2 : prescale;
  assign tick   = (halfCnt == divLim - 8'd1);

  always_comb begin
    strb        = '0;
    nextState   = state;
    strb.txPush = wrEn && (addr == OFS_DATA) && (txCount != FULL_C);
    strb.rxPop  = rdEn && (addr == OFS_DATA) && (rxCount != '0);
    case (state)
      ENG_IDLE: begin
        if (enable && txHasWord && rxCount != FULL_C) begin
          if (loopSel) begin
            strb.loopMove = 1'b1;
          end else begin
            strb.wordLoad = 1'b1;
            nextState     = ENG_SHIFT;
          end
        end
      end
      ENG_SHIFT: begin
        if (tick) begin
          if (!sclkR) begin
            strb.bitSample = 1'b1;
          end else if (bitIdx == '0) begin
            strb.wordDone = 1'b1;
            // the word just finished takes one receive slot this cycle
            if (enable && !loopSel && txHasWord && rxCount < FULL_M1_C)
              strb.wordLoad = 1'b1;
            else
              nextState = ENG_TAIL;
          end
        end
      end
      ENG_TAIL: begin
        if (enable && !loopSel && txHasWord && rxCount != FULL_C) begin
          strb.wordLoad = 1'b1;
          nextState     = ENG_SHIFT;
        end else if (tick && tailHalf) begin
          nextState = ENG_IDLE;
        end
      end
      default: nextState = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ENG_IDLE;
      halfCnt  <= '0;
      sclkR    <= 1'b0;
      csNR     <= 1'b1;
      bitIdx   <= '0;
      tailHalf <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.wordLoad) begin
        halfCnt <= '0;
        sclkR   <= 1'b0;
        csNR    <= 1'b0;
        bitIdx  <= ctrl0[SW-1:0];
      end else begin
        if (state == ENG_IDLE || tick || nextState != state) halfCnt <= '0;
        else                                                 halfCnt <= halfCnt + 8'd1;
        if (state == ENG_SHIFT && tick) begin
          sclkR <= ~sclkR;
          if (sclkR && bitIdx != '0) bitIdx <= bitIdx - 1'b1;
        end
        if (state == ENG_TAIL && nextState == ENG_IDLE) csNR <= 1'b1;
      end
      if (state != ENG_TAIL) tailHalf <= 1'b0;
      else if (tick)         tailHalf <= 1'b1;
    end
  end

  assign sclkOut = sclkR;
  assign csNOut  = csNR;

  // R7: nothing is fetched into a receive FIFO that has no room
  assert_fetch_room_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wordLoad || strb.loopMove) |-> (rxCount != FULL_C));
  // R6: fetches only happen while the port is enabled
  assert_fetch_enabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wordLoad || strb.loopMove) |-> ctrl1[1]);
  // R11: chip select is low in the cycle after a word is loaded
  assert_cs_on_load_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.wordLoad |=> !csNOut);
  // R9: serial clock rests low while the slave is deselected
  assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    csNOut |-> !sclkOut);

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  input  logic [31:0]   busWrData,
  input  logic          busRdEn,
  output logic [31:0]   busRdData,
  output logic          irqOut,
  output logic          sclkOut,
  output logic          csNOut,
  output logic          mosiOut,
  input  logic          misoIn
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int SW = $clog2(DW);

  spiStrobe_t    strb;
  logic [DW-1:0] dataMask, rxHead;
  logic [SW-1:0] bitIdx;
  logic [CW-1:0] txCount, rxCount;

  spi_fifo_ctrl #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .addr(busAddr), .wrEn(busWrEn), .wrData(busWrData),
    .rdEn(busRdEn), .rdData(busRdData),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead),
    .strb(strb), .dataMask(dataMask), .bitIdx(bitIdx),
    .sclkOut(sclkOut), .csNOut(csNOut), .irqOut(irqOut)
  );

  spi_fifo_dp #(.DEPTH(DEPTH), .DW(DW)) i_dp (
    .clk(clk), .rstN(rstN),
    .strb(strb), .wrWord(busWrData[DW-1:0]), .dataMask(dataMask),
    .bitIdx(bitIdx), .misoIn(misoIn), .mosiOut(mosiOut),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead)
  );

endmodule

// File: tb/test_spi_fifo_master.sv
`timescale 1ns/1ps
module test_spi_fifo_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut, sclkOut, csNOut, mosiOut;
  logic        misoIn = 1'b0;

  int testsRun = 0, testsFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_fifo_master i_spi_fifo_master (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .irqOut(irqOut), .sclkOut(sclkOut), .csNOut(csNOut),
    .mosiOut(mosiOut), .misoIn(misoIn)
  );

  // ---------------- slave model (8-bit words) ----------------
  function automatic logic [15:0] resp(input int k);
    resp = 16'h5A3C + 16'(k) * 16'h1111;
  endfunction

  int          slvIdx = 0, slvCnt = 0, csFalls = 0;
  logic [15:0] slvShift = '0, slvRx = '0;
  logic [7:0]  slvGot [8];
  time         tRise = 0, halfMeas = 0, tLastFall = 0, tailMeas = 0;

  always @(negedge csNOut) begin
    csFalls++;
    slvShift = resp(slvIdx);
    misoIn   = slvShift[7];
    slvCnt   = 0;
  end
  always @(posedge csNOut) tailMeas = $time - tLastFall;
  always @(posedge sclkOut) begin
    tRise = $time;
    slvRx = {slvRx[14:0], mosiOut};
    slvCnt++;
    if (slvCnt == 8) begin
      if (slvIdx < 8) slvGot[slvIdx] = slvRx[7:0];
      slvIdx++;
      slvCnt = 0;
    end
  end
  always @(negedge sclkOut) begin
    halfMeas  = $time - tRise;
    tLastFall = $time;
    if (slvCnt == 0) slvShift = resp(slvIdx);
    else             slvShift = slvShift << 1;
    misoIn = slvShift[7];
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (10) @(negedge clk);
    for (int n = 0; n < 4000 && !csNOut; n++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // {size field, written word, expected read-back}, loopback mode
  localparam logic [35:0] VEC [6] = '{
    {4'd7,  16'h1234, 16'h0034},
    {4'd15, 16'hBEEF, 16'hBEEF},
    {4'd3,  16'h00FF, 16'h000F},
    {4'd0,  16'hFFFF, 16'h0001},
    {4'd11, 16'hA5C3, 16'h05C3},
    {4'd8,  16'h03FF, 16'h01FF}
  };

  initial begin
    #1_000_000;
    if (!finished) begin
      testsFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R4 reset state
    busRead(12'h00C, rd); check("R1 status", rd, 32'h03);
    busRead(12'h018, rd); check("R1 raw", rd, 32'h08);
    busRead(12'h014, rd); check("R1 mask", rd, 32'h00);
    check("R1 irq/cs/sclk", {29'd0, irqOut, csNOut, sclkOut}, 32'h2);

    // R12 identification window and inert DMA slot
    for (int i = 0; i < 8; i++) begin
      logic [7:0] exp;
      case (i)
        0: exp = 8'h22; 1: exp = 8'h10; 2: exp = 8'h04; 3: exp = 8'h00;
        4: exp = 8'h0D; 5: exp = 8'hF0; 6: exp = 8'h05; default: exp = 8'hB1;
      endcase
      busRead(12'hFE0 + 12'(i*4), rd); check("R12 id", rd, 32'(exp));
    end
    busWrite(12'h020, 32'hFFFF_FFFF);
    busRead(12'h020, rd); check("R12 dma", rd, 32'h0);

    // R10 prescale keeps 8 bits
    busWrite(12'h010, 32'h1FF);
    busRead(12'h010, rd); check("R10 prescale", rd, 32'hFF);

    // R2 / R8 masking through loopback, table-driven
    busWrite(12'h004, 32'h3);
    foreach (VEC[i]) begin
      busWrite(12'h000, 32'(VEC[i][35:32]));
      busWrite(12'h008, 32'(VEC[i][31:16]));
      repeat (4) @(negedge clk);
      busRead(12'h008, rd); check("R2 R8 loopback mask", rd, 32'(VEC[i][15:0]));
    end
    check("R8 cs untouched", 32'(csFalls), 32'd0);

    // R6 disabled: words stay queued
    busWrite(12'h000, 32'hF);
    busWrite(12'h004, 32'h1);
    for (int v = 1; v <= 3; v++) busWrite(12'h008, 32'(v));
    repeat (10) @(negedge clk);
    busRead(12'h00C, rd); check("R6 held status", rd, 32'h12);

    // R3 fill to 8, ninth dropped
    for (int v = 4; v <= 9; v++) busWrite(12'h008, 32'(v));
    busRead(12'h00C, rd); check("R3 R4 tx full", rd, 32'h10);
    busRead(12'h018, rd); check("R5 raw tx8", rd, 32'h00);

    // R7 enable: receive fills, then hold-off
    busWrite(12'h004, 32'h3);
    repeat (12) @(negedge clk);
    busRead(12'h00C, rd); check("R4 rx full", rd, 32'h0F);
    busRead(12'h018, rd); check("R5 raw both", rd, 32'h0C);
    busWrite(12'h008, 32'hA);
    busWrite(12'h008, 32'hB);
    repeat (6) @(negedge clk);
    busRead(12'h00C, rd); check("R7 hold-off status", rd, 32'h1E);
    busWrite(12'h014, 32'h4);
    busRead(12'h01C, rd); check("R5 masked", rd, 32'h04);
    check("R5 irq high", 32'(irqOut), 32'h1);
    for (int v = 1; v <= 10; v++) begin
      busRead(12'h008, rd);
      check("R7 R3 order after resume", rd, (v <= 8) ? 32'(v) : 32'(v + 1));
      @(negedge clk);
    end
    busRead(12'h00C, rd); check("R7 drained", rd, 32'h03);
    busRead(12'h008, rd); check("R3 empty read", rd, 32'h0);
    busRead(12'h00C, rd); check("R3 empty no change", rd, 32'h03);
    check("R5 irq low", 32'(irqOut), 32'h0);
    busWrite(12'h014, 32'h8);
    check("R5 tx irq", 32'(irqOut), 32'h1);
    busWrite(12'h014, 32'h0);

    // R9 / R10 / R11 serial burst, 8-bit words, prescale 3
    busWrite(12'h000, 32'h7);
    busWrite(12'h010, 32'h3);
    busWrite(12'h004, 32'h2);
    busWrite(12'h008, 32'h181);
    busWrite(12'h008, 32'h42);
    busWrite(12'h008, 32'h3C);
    waitIdle();
    check("R11 one burst", 32'(csFalls), 32'd1);
    check("R10 half period P=3", 32'(halfMeas), 32'd30);
    check("R11 tail", 32'(tailMeas), 32'd60);
    check("R9 slave word0", 32'(slvGot[0]), 32'h81);
    check("R9 slave word1", 32'(slvGot[1]), 32'h42);
    check("R9 slave word2", 32'(slvGot[2]), 32'h3C);
    for (int k = 0; k < 3; k++) begin
      busRead(12'h008, rd); check("R9 received", rd, 32'(resp(k) & 16'h00FF));
    end
    busRead(12'h00C, rd); check("R9 one per word", rd, 32'h03);

    // R10 prescale 0 acts as 2
    busWrite(12'h010, 32'h0);
    busWrite(12'h008, 32'h5A);
    waitIdle();
    check("R10 half period P=0", 32'(halfMeas), 32'd20);
    check("R11 tail P=0", 32'(tailMeas), 32'd40);
    check("R11 second burst", 32'(csFalls), 32'd2);
    check("R9 slave word3", 32'(slvGot[3]), 32'h5A);
    busRead(12'h008, rd); check("R9 received word3", rd, 32'(resp(3) & 16'h00FF));

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end
endmodule